// File: doc/BRIEF.md
# Chunked Systolic Multi-Word Multiplier

The block forms the product of two unsigned multi-word operands A and B, each `len` words long, and streams out the low `len_p` words of that product, least significant first. `len_p` is normally `2*len`. A shorter `len_p` gives a truncated product, and a longer one pads the stream with zero words. The arithmetic is done by a fixed row of `NPE` processing elements. For every word of A, the row is swept across B in slices of `NPE` words called chunks, so an operand longer than the row costs more cycles, not more multipliers.

Each element computes `a*b + t + c` into a double-width value. The low word is its sum and the high word is its carry. Every element keeps a carry word and an accumulator word for each chunk, held in small register files that are indexed by chunk number. After each chunk step, the sums shift down one element. The sum of element 0 moves across the boundary into the last accumulator slot of the previous chunk. The sum of element 0 in chunk 0 is the next product word.

The operand memories sit outside the block and are read combinationally. `a_addr` selects one word of A. `b_chunk` selects a slice of B, which comes back as `NPE` words packed together with word `j` in bits `[j*W +: W]`. A one-cycle `start` loads the lengths. The block then emits one word per outer step on `p_word`/`p_valid` and pulses `done` once the stream is complete.

Top module: `chunked_sysmul`

## Requirements
- R1: For `1 <= len <= NPE*MAX_CHUNKS` and `len_p >= 1`, the block emits exactly `len_p` words with `p_valid` high, one per cycle of `p_valid`. Word `i` of the stream equals word `i` of A*B, in ascending order.
- R2: Each outer step takes ceil(`len`/`NPE`) cycles, so consecutive `p_valid` pulses of one run are exactly that many cycles apart.
- R3: A words at index `>= len` and B words at index `>= len` do not affect the result, even when the memories hold nonzero data there.
- R4: All per-chunk carry and accumulator state is cleared when a run starts, so a run's output does not depend on any earlier run.
- R5: `done` is high for exactly one cycle, in the cycle right after the last `p_valid` of the run. No product word is outstanding at that point.
- R6: A `start` pulse while a run is in progress is ignored. The current run keeps its lengths and output, and no second run follows it.
- R7: When `len_p < 2*len`, the stream is the low `len_p` words of the product. When `len_p > 2*len`, every word past index `2*len-1` is zero.
- R8: After reset, `p_valid` and `done` are low until a run is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (used only when idle) |
| len | input | LEN_W | Operand length in words |
| len_p | input | LEN_W+1 | Number of product words to emit |
| a_addr | output | LEN_W | Word index into A |
| a_word | input | W | A word at `a_addr`, combinational |
| b_chunk | output | CH_W | Chunk index into B |
| b_words | input | NPE*W | B words `b_chunk*NPE+j`, word j at bits `[j*W +: W]` |
| p_word | output | W | Product word |
| p_valid | output | 1 | `p_word` is valid this cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with `W=32`, `NPE=4` and `MAX_CHUNKS=4`. Operands can therefore be 1 to 16 words long and need one to four chunk passes per outer step. The runs cover lengths that fill the row exactly, lengths that leave the last chunk partly padded, and a single-word operand. An all-ones operand run pushes the largest carries across chunk boundaries. Truncated and zero-padded output lengths, stray `start` pulses during a run, and runs placed back to back after carry-heavy data are also exercised.

// File: rtl/chunked_sysmul.sv
module chunked_sysmul #(
  parameter int W          = 32,
  parameter int NPE        = 4,
  parameter int MAX_CHUNKS = 4,
  localparam int LEN_W     = $clog2(NPE*MAX_CHUNKS + 1),
  localparam int CH_W      = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [LEN_W-1:0]     len,
  input  logic [LEN_W:0]       len_p,
  output logic [LEN_W-1:0]     a_addr,
  input  logic [W-1:0]         a_word,
  output logic [CH_W-1:0]      b_chunk,
  input  logic [NPE*W-1:0]     b_words,
  output logic [W-1:0]         p_word,
  output logic                 p_valid,
  output logic                 done
);

  logic             busy, fin;
  logic [LEN_W:0]   i_q, lenp_q;
  logic [LEN_W-1:0] len_q;
  logic [CH_W-1:0]  k_q;
  logic [W-1:0]     t_mem [MAX_CHUNKS][NPE];
  logic [W-1:0]     c_mem [MAX_CHUNKS][NPE];
  logic [W-1:0]     lo [NPE];
  logic [W-1:0]     hi [NPE];
  logic [W-1:0]     a_eff;
  logic [LEN_W:0]   nch;
  logic             last_chunk, last_word;

  assign a_addr     = i_q[LEN_W-1:0];
  assign b_chunk    = k_q;
  assign a_eff      = (i_q < {1'b0, len_q}) ? a_word : '0;
  assign nch        = ({1'b0, len_q} + (LEN_W+1)'(NPE-1)) / (LEN_W+1)'(NPE);
  assign last_chunk = ((LEN_W+1)'(k_q) + (LEN_W+1)'(1)) == nch;
  assign last_word  = (i_q + (LEN_W+1)'(1)) == lenp_q;

  for (genvar j = 0; j < NPE; j++) begin : g_pe
    logic [W-1:0]   b_eff;
    logic [2*W-1:0] acc;
    assign b_eff = ((int'(k_q) * NPE + j) < int'(len_q)) ? b_words[j*W +: W] : '0;
    assign acc   = a_eff * b_eff + {{W{1'b0}}, t_mem[k_q][j]} + {{W{1'b0}}, c_mem[k_q][j]};
    assign lo[j] = acc[W-1:0];
    assign hi[j] = acc[2*W-1:W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      fin     <= 1'b0;
      p_valid <= 1'b0;
      done    <= 1'b0;
      p_word  <= '0;
      i_q     <= '0;
      k_q     <= '0;
      len_q   <= '0;
      lenp_q  <= '0;
    end else begin
      p_valid <= 1'b0;
      done    <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          fin    <= 1'b0;
          i_q    <= '0;
          k_q    <= '0;
          len_q  <= len;
          lenp_q <= len_p;
          for (int c = 0; c < MAX_CHUNKS; c++)
            for (int j = 0; j < NPE; j++) begin
              t_mem[c][j] <= '0;
              c_mem[c][j] <= '0;
            end
        end
      end else if (fin) begin
        busy <= 1'b0;
        fin  <= 1'b0;
        done <= 1'b1;
      end else begin
        for (int j = 0; j < NPE; j++) c_mem[k_q][j] <= hi[j];
        for (int j = 1; j < NPE; j++) t_mem[k_q][j-1] <= lo[j];
        if (k_q != '0) t_mem[k_q - 1'b1][NPE-1] <= lo[0];
        if (k_q == '0) begin
          p_valid <= 1'b1;
          p_word  <= lo[0];
          if (last_word) fin <= 1'b1;
        end
        if (last_chunk) begin
          k_q <= '0;
          i_q <= i_q + 1'b1;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assert_valid_from_run_R1: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> $past(busy) && !$past(fin));

  assert_chunk_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |-> ((LEN_W+1)'(k_q) < nch));

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(p_valid));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(len_q) && $stable(lenp_q));

  assert_tail_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin && k_q == '0 && i_q >= ({1'b0, len_q} << 1)) |=> (p_word == '0));

endmodule

// File: tb/chunked_sysmul_tb.sv
module chunked_sysmul_tb;
  localparam int W = 32, NPE = 4, MAX_CHUNKS = 4;
  localparam int LEN_W = $clog2(NPE*MAX_CHUNKS + 1);
  localparam int CH_W = $clog2(MAX_CHUNKS);
  localparam int MAXL = NPE*MAX_CHUNKS;

  logic clk = 0, rst = 1, start = 0;
  logic [LEN_W-1:0] len = '0;
  logic [LEN_W:0] len_p = '0;
  logic [LEN_W-1:0] a_addr;
  logic [W-1:0] a_word;
  logic [CH_W-1:0] b_chunk;
  logic [NPE*W-1:0] b_words;
  logic [W-1:0] p_word;
  logic p_valid, done;

  logic [W-1:0] a_mem [32];
  logic [W-1:0] b_mem [MAXL];
  logic [W-1:0] expq [$];
  int checks = 0, errors = 0, cyc = 0, last_v = -1, exp_nch = 1;
  bit first_v = 1;

  always #5 clk = ~clk;

  assign a_word = a_mem[a_addr];
  always_comb
    for (int j = 0; j < NPE; j++) b_words[j*W +: W] = b_mem[int'(b_chunk)*NPE + j];

  chunked_sysmul #(.W(W), .NPE(NPE), .MAX_CHUNKS(MAX_CHUNKS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .len(len), .len_p(len_p),
    .a_addr(a_addr), .a_word(a_word), .b_chunk(b_chunk), .b_words(b_words),
    .p_word(p_word), .p_valid(p_valid), .done(done));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && p_valid) begin
      if (expq.size() == 0) check(0, "R6 unexpected word", 64'(p_word), 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        check(p_word == e, "R1/R3/R4/R7 product word", 64'(p_word), 64'(e));
      end
      if (!first_v) check(cyc - last_v == exp_nch, "R2 word spacing", 64'(cyc - last_v), 64'(exp_nch));
      first_v = 0;
      last_v = cyc;
    end
    if (!rst && done) begin
      check(expq.size() == 0, "R5 words outstanding at done", 64'(expq.size()), 0);
      check(cyc - last_v == 1, "R5 done follows last word", 64'(cyc - last_v), 1);
    end
  end

  task automatic run(input int n, input int np, input bit ones, input bit poke);
    logic [W-1:0] pr [2*MAXL+1];
    for (int x = 0; x < 32; x++) a_mem[x] = ones && x < n ? '1 : $urandom;
    for (int x = 0; x < MAXL; x++) b_mem[x] = ones && x < n ? '1 : $urandom;
    for (int x = 0; x <= 2*MAXL; x++) pr[x] = '0;
    for (int x = 0; x < n; x++) begin
      logic [63:0] cy;
      cy = 0;
      for (int y = 0; y < n; y++) begin
        logic [63:0] tmp;
        tmp = 64'(a_mem[x]) * 64'(b_mem[y]) + 64'(pr[x+y]) + cy;
        pr[x+y] = tmp[31:0];
        cy = {32'b0, tmp[63:32]};
      end
      pr[x+n] = cy[31:0];
    end
    for (int x = 0; x < np; x++) expq.push_back(x < 2*n ? pr[x] : '0);
    exp_nch = (n + NPE - 1) / NPE;
    first_v = 1;
    @(negedge clk);
    start = 1; len = LEN_W'(n); len_p = (LEN_W+1)'(np);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; len = 2; len_p = 3;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R1 word count", 64'(expq.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(p_valid == 0, "R8 p_valid after reset", 64'(p_valid), 0);
    check(done == 0, "R8 done after reset", 64'(done), 0);
    rst = 0;
    repeat (2) @(negedge clk);
    check(p_valid == 0 && done == 0, "R8 idle without start", 64'({p_valid, done}), 0);
    run(4, 8, 0, 0);    // R1 one full chunk
    run(5, 10, 0, 0);   // R2 R3 partial second chunk
    run(16, 32, 0, 0);  // R2 max chunks
    run(1, 2, 0, 0);    // R1 single word
    run(8, 16, 1, 0);   // R4 carry heavy
    run(3, 6, 0, 0);    // R4 back to back after all-ones
    run(7, 5, 0, 0);    // R7 truncated
    run(3, 9, 0, 0);    // R7 zero tail
    run(9, 18, 0, 1);   // R6 stray start
    run(13, 26, 1, 0);  // R2 R4 carries over 4 chunks
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule